// File: doc/BRIEF.md
# System Control Register Bank with Privilege Gating

This block holds the system-control registers that a processor core reaches with its coprocessor move instructions. A request names a register by four fields: a primary register number, a first opcode, a secondary register number and a second opcode. With the request the core says whether it is a write or a read, and whether it is running in a privileged mode. Reads return the register contents one cycle later with a strobe. Writes update the stored register in the same clock edge that accepts them.

Most registers can be reached only from privileged code. Three thread-identifier registers share one address group but each has its own access rights. Identification values are constants and cannot be written. A tuple that is not implemented, or that is locked against the current mode, reads as zero and does not trap. Writes to cache, TLB, wait-for-interrupt and barrier tuples do not store anything. Each one instead raises a one-cycle pulse that carries a 4-bit operation code, which the memory system acts on.

Top module: `sysreg_bank`

## Requirements
- R1: After reset, privileged reads return these values. Main ID (0,0,0,0) reads 0x410FB024 and TLB type (0,0,0,3) reads 0x00000800. Control (1,0,0,0) reads 0x00054078 and auxiliary control (1,0,0,1) reads 0x0000000F. Data cache lockdown (9,0,0,0) reads 0xFFFFFFF0. Remap registers (10,0,2,0) and (10,0,2,1) read 0x00098AA4 and 0x44E048E0. Every other stored register reads 0. Tuples are written (CRn,opc1,CRm,opc2).
- R2: A read request yields rd_valid high for exactly the next cycle, with the data on rd_data in that cycle. When rd_valid is low, rd_data is 0. Outputs are 0 during and just after reset.
- R3: The register at (13,0,0,2) can be read and written in any mode.
- R4: The register at (13,0,0,3) can be read in any mode but can be written only when privileged. An unprivileged write leaves it unchanged.
- R5: The register at (13,0,0,4) can be reached only when privileged. In user mode a read returns 0 and a write is ignored.
- R6: A read of an unimplemented tuple still gives rd_valid, with data 0. A write to an unimplemented tuple changes no register and raises no pulse.
- R7: All other stored registers can be reached only when privileged. In user mode a read returns 0 and a write is ignored.
- R8: The identification tuples (0,0,0,0) and (0,0,0,3) are read-only, and a write to them is ignored.
- R9: A privileged write to a maintenance tuple raises op_valid for exactly the next cycle with this op_code: (7,0,5,0)=1, (7,0,6,0)=2, (7,0,10,0)=3, (7,0,14,0)=4, (8,0,7,0)=5, (7,0,0,4)=6. In user mode these tuples raise no pulse.
- R10: A write in any mode to (7,0,5,4) gives op_code 7 (prefetch flush), to (7,0,10,4) gives 8 (synchronisation barrier) and to (7,0,10,5) gives 9 (memory barrier). op_code is 0 whenever op_valid is low.
- R11: A read of an operation tuple returns 0 and raises no pulse. A read never raises op_valid.
- R12: A privileged write stores its full 32-bit value, and a later read returns it, at each of these tuples: (1,0,0,0..2), (2,0,0,0..2), (3,0,0,0), (5,0,0,0..1), (6,0,0,0..1), (9,0,0,0), (10,0,0,0), (10,0,2,0..1), (13,0,0,0..1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = move to register (write), 0 = read |
| req_priv | input | 1 | Core is in a privileged mode |
| req_crn | input | 4 | Primary register number |
| req_opc1 | input | 3 | First opcode |
| req_crm | input | 4 | Secondary register number |
| req_opc2 | input | 3 | Second opcode |
| req_wdata | input | 32 | Write value |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 32 | Read data, 0 when rd_valid is low |
| op_valid | output | 1 | Maintenance or barrier pulse |
| op_code | output | 4 | Code of the requested operation |

## Verification
Some properties are checked by assertions on every cycle. Reads and operation pulses never coincide, and op_valid never comes with a zero code. rd_data is zero whenever no read is strobed. An unprivileged read of the control group returns zero, and an unprivileged write never disturbs the privileged thread register. Other behaviour shows only in the bench's scenarios. These are the exact reset values, the readback of every stored tuple, the three-way rights in the thread group, the read-only ID tuples, and the code value for each operation tuple. The bench tests them against a behavioural model on every clock.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

   localparam int KEY_W = 14;

   // access classes for a decoded tuple
   typedef enum logic [2:0] {
      AC_NONE,
      AC_ID,
      AC_PRIV,
      AC_USER,
      AC_USER_RO,
      AC_OP_PRIV,
      AC_OP_USER
   } acc_e;

   // stored register slots
   localparam int IX_CTRL  = 0;
   localparam int IX_AUX   = 1;
   localparam int IX_CPAC  = 2;
   localparam int IX_TTB0  = 3;
   localparam int IX_TTB1  = 4;
   localparam int IX_TTBC  = 5;
   localparam int IX_DACR  = 6;
   localparam int IX_DFSR  = 7;
   localparam int IX_IFSR  = 8;
   localparam int IX_DFAR  = 9;
   localparam int IX_WFAR  = 10;
   localparam int IX_DLCK  = 11;
   localparam int IX_TLCK  = 12;
   localparam int IX_PRRR  = 13;
   localparam int IX_NMRR  = 14;
   localparam int IX_PID   = 15;
   localparam int IX_CTX   = 16;
   localparam int IX_TURW  = 17;
   localparam int IX_TURO  = 18;
   localparam int IX_TPRW  = 19;
   localparam int NREG     = 20;

   // operation codes
   localparam logic [3:0] OPC_NONE    = 4'd0;
   localparam logic [3:0] OPC_IC_INV  = 4'd1;
   localparam logic [3:0] OPC_DC_INV  = 4'd2;
   localparam logic [3:0] OPC_DC_CLN  = 4'd3;
   localparam logic [3:0] OPC_DC_CI   = 4'd4;
   localparam logic [3:0] OPC_TLB_INV = 4'd5;
   localparam logic [3:0] OPC_WFI     = 4'd6;
   localparam logic [3:0] OPC_PF_FL   = 4'd7;
   localparam logic [3:0] OPC_DSYNC   = 4'd8;
   localparam logic [3:0] OPC_DMEM    = 4'd9;

   function automatic logic [KEY_W-1:0] tup(input int n, input int o1, input int m, input int o2);
      return {4'(n), 3'(o1), 4'(m), 3'(o2)};
   endfunction

   function automatic logic [31:0] rst_val(input int ix);
      case (ix)
         IX_CTRL: return 32'h0005_4078;
         IX_AUX:  return 32'h0000_000F;
         IX_DLCK: return 32'hFFFF_FFF0;
         IX_PRRR: return 32'h0009_8AA4;
         IX_NMRR: return 32'h44E0_48E0;
         default: return 32'h0;
      endcase
   endfunction

endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
   import sysreg_pkg::*;
#(
   parameter int          DATA_W  = 32,
   parameter int          IX_W    = 5,
   parameter logic [31:0] ID_MAIN = 32'h410F_B024,
   parameter logic [31:0] ID_TLB  = 32'h0000_0800
) (
   input  logic [3:0]        crn,
   input  logic [2:0]        opc1,
   input  logic [3:0]        crm,
   input  logic [2:0]        opc2,
   input  logic              priv,
   output logic              rd_ok,
   output logic              rd_is_const,
   output logic [DATA_W-1:0] rd_const,
   output logic [IX_W-1:0]   idx,
   output logic              wr_ok,
   output logic [3:0]        op_code
);

   logic [KEY_W-1:0] key;
   acc_e             cls;
   logic [3:0]       code;

   assign key = {crn, opc1, crm, opc2};

   always_comb begin
      cls      = AC_NONE;
      idx      = '0;
      code     = OPC_NONE;
      rd_const = '0;
      case (key)
         tup(0,0,0,0):   begin cls = AC_ID; rd_const = DATA_W'(ID_MAIN); end
         tup(0,0,0,3):   begin cls = AC_ID; rd_const = DATA_W'(ID_TLB);  end
         tup(1,0,0,0):   begin cls = AC_PRIV; idx = IX_W'(IX_CTRL); end
         tup(1,0,0,1):   begin cls = AC_PRIV; idx = IX_W'(IX_AUX);  end
         tup(1,0,0,2):   begin cls = AC_PRIV; idx = IX_W'(IX_CPAC); end
         tup(2,0,0,0):   begin cls = AC_PRIV; idx = IX_W'(IX_TTB0); end
         tup(2,0,0,1):   begin cls = AC_PRIV; idx = IX_W'(IX_TTB1); end
         tup(2,0,0,2):   begin cls = AC_PRIV; idx = IX_W'(IX_TTBC); end
         tup(3,0,0,0):   begin cls = AC_PRIV; idx = IX_W'(IX_DACR); end
         tup(5,0,0,0):   begin cls = AC_PRIV; idx = IX_W'(IX_DFSR); end
         tup(5,0,0,1):   begin cls = AC_PRIV; idx = IX_W'(IX_IFSR); end
         tup(6,0,0,0):   begin cls = AC_PRIV; idx = IX_W'(IX_DFAR); end
         tup(6,0,0,1):   begin cls = AC_PRIV; idx = IX_W'(IX_WFAR); end
         tup(9,0,0,0):   begin cls = AC_PRIV; idx = IX_W'(IX_DLCK); end
         tup(10,0,0,0):  begin cls = AC_PRIV; idx = IX_W'(IX_TLCK); end
         tup(10,0,2,0):  begin cls = AC_PRIV; idx = IX_W'(IX_PRRR); end
         tup(10,0,2,1):  begin cls = AC_PRIV; idx = IX_W'(IX_NMRR); end
         tup(13,0,0,0):  begin cls = AC_PRIV; idx = IX_W'(IX_PID);  end
         tup(13,0,0,1):  begin cls = AC_PRIV; idx = IX_W'(IX_CTX);  end
         tup(13,0,0,2):  begin cls = AC_USER; idx = IX_W'(IX_TURW); end
         tup(13,0,0,3):  begin cls = AC_USER_RO; idx = IX_W'(IX_TURO); end
         tup(13,0,0,4):  begin cls = AC_PRIV; idx = IX_W'(IX_TPRW); end
         tup(7,0,5,0):   begin cls = AC_OP_PRIV; code = OPC_IC_INV;  end
         tup(7,0,6,0):   begin cls = AC_OP_PRIV; code = OPC_DC_INV;  end
         tup(7,0,10,0):  begin cls = AC_OP_PRIV; code = OPC_DC_CLN;  end
         tup(7,0,14,0):  begin cls = AC_OP_PRIV; code = OPC_DC_CI;   end
         tup(8,0,7,0):   begin cls = AC_OP_PRIV; code = OPC_TLB_INV; end
         tup(7,0,0,4):   begin cls = AC_OP_PRIV; code = OPC_WFI;     end
         tup(7,0,5,4):   begin cls = AC_OP_USER; code = OPC_PF_FL;   end
         tup(7,0,10,4):  begin cls = AC_OP_USER; code = OPC_DSYNC;   end
         tup(7,0,10,5):  begin cls = AC_OP_USER; code = OPC_DMEM;    end
         default:        cls = AC_NONE;
      endcase
   end

   always_comb begin
      rd_is_const = (cls == AC_ID);
      rd_ok       = ((cls == AC_ID || cls == AC_PRIV) && priv) ||
                    cls == AC_USER || cls == AC_USER_RO;
      wr_ok       = ((cls == AC_PRIV || cls == AC_USER_RO) && priv) || cls == AC_USER;
      op_code     = ((cls == AC_OP_PRIV && priv) || cls == AC_OP_USER) ? code : OPC_NONE;
   end

endmodule

// File: rtl/sysreg_store.sv
module sysreg_store
   import sysreg_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int N_REG  = 20,
   parameter int IX_W   = 5
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [IX_W-1:0]               widx,
   input  logic [DATA_W-1:0]             wdata,
   output logic [N_REG-1:0][DATA_W-1:0]  regs_q
);

   for (genvar g = 0; g < N_REG; g++) begin : g_slot
      localparam logic [DATA_W-1:0] RV = DATA_W'(rst_val(g));
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs_q[g] <= RV;
         else if (we && widx == IX_W'(g))
            regs_q[g] <= wdata;
      end
   end

   assert_widx_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (int'(widx) < N_REG));

endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
   import sysreg_pkg::*;
#(
   parameter int          DATA_W  = 32,
   parameter int          OP_W    = 4,
   parameter logic [31:0] ID_MAIN = 32'h410F_B024,
   parameter logic [31:0] ID_TLB  = 32'h0000_0800
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_priv,
   input  logic [3:0]        req_crn,
   input  logic [2:0]        req_opc1,
   input  logic [3:0]        req_crm,
   input  logic [2:0]        req_opc2,
   input  logic [31:0]       req_wdata,
   output logic              rd_valid,
   output logic [31:0]       rd_data,
   output logic              op_valid,
   output logic [3:0]        op_code
);

   localparam int IX_W = $clog2(NREG);

   if (DATA_W != 32) begin : g_bad_width
      $error("sysreg_bank: DATA_W must be 32");
   end
   if (OP_W != 4) begin : g_bad_opw
      $error("sysreg_bank: OP_W must be 4");
   end

   logic                        is_rd, is_wr;
   logic                        rd_ok, rd_is_const, wr_ok;
   logic [DATA_W-1:0]           rd_const, rd_sel;
   logic [IX_W-1:0]             idx;
   logic [3:0]                  dec_op;
   logic [NREG-1:0][DATA_W-1:0] regs_q;

   assign is_rd = req_valid && !req_write;
   assign is_wr = req_valid &&  req_write;

   sysreg_decode #(
      .DATA_W (DATA_W),
      .IX_W   (IX_W),
      .ID_MAIN(ID_MAIN),
      .ID_TLB (ID_TLB)
   ) u_dec (
      .crn        (req_crn),
      .opc1       (req_opc1),
      .crm        (req_crm),
      .opc2       (req_opc2),
      .priv       (req_priv),
      .rd_ok      (rd_ok),
      .rd_is_const(rd_is_const),
      .rd_const   (rd_const),
      .idx        (idx),
      .wr_ok      (wr_ok),
      .op_code    (dec_op)
   );

   sysreg_store #(
      .DATA_W(DATA_W),
      .N_REG (NREG),
      .IX_W  (IX_W)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (is_wr && wr_ok),
      .widx  (idx),
      .wdata (req_wdata),
      .regs_q(regs_q)
   );

   always_comb begin
      rd_sel = '0;
      if (rd_ok)
         rd_sel = rd_is_const ? rd_const : regs_q[idx];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
         op_valid <= 1'b0;
         op_code  <= '0;
      end else begin
         rd_valid <= is_rd;
         rd_data  <= is_rd ? rd_sel : '0;
         op_valid <= is_wr && (dec_op != OPC_NONE);
         op_code  <= is_wr ? dec_op : OPC_NONE;
      end
   end

   assert_rd_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> rd_data == '0);

   assert_op_code_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |-> op_code != '0);

   assert_read_no_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> !op_valid);

   assert_rd_op_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_valid, op_valid}));

   assert_user_ctrl_hidden_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && !req_priv && req_crn == 4'd1) |=> rd_data == '0);

   assert_user_prw_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && !req_priv) |=> $stable(regs_q[IX_TPRW]));

endmodule

// File: tb/test_sysreg_bank.sv
`timescale 1ns/1ps
module test_sysreg_bank;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_write, req_priv;
   logic [3:0]  req_crn, req_crm;
   logic [2:0]  req_opc1, req_opc2;
   logic [31:0] req_wdata;
   logic        rd_valid, op_valid;
   logic [31:0] rd_data;
   logic [3:0]  op_code;

   always #2.5 clk = ~clk;

   sysreg_bank i_sysreg_bank (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_priv(req_priv), .req_crn(req_crn), .req_opc1(req_opc1), .req_crm(req_crm),
      .req_opc2(req_opc2), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
      .op_valid(op_valid), .op_code(op_code)
   );

   int n_run = 0;
   int n_fail = 0;
   bit finished = 0;

   // behavioural reference model
   localparam int C_NONE = 0, C_ID = 1, C_PRIV = 2, C_USER = 3, C_URO = 4, C_OPP = 5, C_OPU = 6;
   logic [31:0] mdl [int];

   function automatic int k(int n, int o1, int m, int o2);
      return (n << 10) | (o1 << 7) | (m << 3) | o2;
   endfunction

   function automatic int cls_of(int key);
      if (key == k(0,0,0,0) || key == k(0,0,0,3)) return C_ID;
      if (key == k(13,0,0,2)) return C_USER;
      if (key == k(13,0,0,3)) return C_URO;
      if (key == k(7,0,5,4) || key == k(7,0,10,4) || key == k(7,0,10,5)) return C_OPU;
      if (key == k(7,0,5,0) || key == k(7,0,6,0) || key == k(7,0,10,0) ||
          key == k(7,0,14,0) || key == k(8,0,7,0) || key == k(7,0,0,4)) return C_OPP;
      if (mdl.exists(key)) return C_PRIV;
      return C_NONE;
   endfunction

   function automatic logic [3:0] code_of(int key);
      if (key == k(7,0,5,0))  return 4'd1;
      if (key == k(7,0,6,0))  return 4'd2;
      if (key == k(7,0,10,0)) return 4'd3;
      if (key == k(7,0,14,0)) return 4'd4;
      if (key == k(8,0,7,0))  return 4'd5;
      if (key == k(7,0,0,4))  return 4'd6;
      if (key == k(7,0,5,4))  return 4'd7;
      if (key == k(7,0,10,4)) return 4'd8;
      if (key == k(7,0,10,5)) return 4'd9;
      return 4'd0;
   endfunction

   task automatic model_reset();
      mdl.delete();
      foreach (stored_keys[i]) mdl[stored_keys[i]] = 32'h0;
      mdl[k(1,0,0,0)]  = 32'h0005_4078;
      mdl[k(1,0,0,1)]  = 32'h0000_000F;
      mdl[k(9,0,0,0)]  = 32'hFFFF_FFF0;
      mdl[k(10,0,2,0)] = 32'h0009_8AA4;
      mdl[k(10,0,2,1)] = 32'h44E0_48E0;
      mdl[k(13,0,0,2)] = 32'h0;
      mdl[k(13,0,0,3)] = 32'h0;
   endtask

   int stored_keys [20];
   initial begin
      stored_keys = '{k(1,0,0,0), k(1,0,0,1), k(1,0,0,2), k(2,0,0,0), k(2,0,0,1),
                      k(2,0,0,2), k(3,0,0,0), k(5,0,0,0), k(5,0,0,1), k(6,0,0,0),
                      k(6,0,0,1), k(9,0,0,0), k(10,0,0,0), k(10,0,2,0), k(10,0,2,1),
                      k(13,0,0,0), k(13,0,0,1), k(13,0,0,4), k(13,0,0,2), k(13,0,0,3)};
   end

   // pending expectation for the cycle after the last drive
   logic        e_rv = 0, e_ov = 0;
   logic [31:0] e_rd = 0;
   logic [3:0]  e_oc = 0;
   string       e_tag = "R2";

   task automatic check_pending();
      n_run++;
      if (rd_valid !== e_rv || rd_data !== e_rd || op_valid !== e_ov || op_code !== e_oc) begin
         n_fail++;
         $display("FAIL %s: got rv=%0b rd=%h ov=%0b oc=%0d exp rv=%0b rd=%h ov=%0b oc=%0d",
                  e_tag, rd_valid, rd_data, op_valid, op_code, e_rv, e_rd, e_ov, e_oc);
      end
   endtask

   task automatic idle(string tag);
      @(negedge clk);
      check_pending();
      req_valid = 0; req_write = 0;
      e_rv = 0; e_rd = 0; e_ov = 0; e_oc = 0; e_tag = tag;
   endtask

   task automatic req(bit w, bit p, int n, int o1, int m, int o2, logic [31:0] d, string tag);
      int key = k(n, o1, m, o2);
      int c   = cls_of(key);
      @(negedge clk);
      check_pending();
      req_valid = 1; req_write = w; req_priv = p;
      req_crn = 4'(n); req_opc1 = 3'(o1); req_crm = 4'(m); req_opc2 = 3'(o2); req_wdata = d;
      e_tag = tag; e_rv = 0; e_rd = 0; e_ov = 0; e_oc = 0;
      if (!w) begin
         e_rv = 1;
         if (c == C_ID && p)
            e_rd = (key == k(0,0,0,0)) ? 32'h410F_B024 : 32'h0000_0800;
         else if ((c == C_PRIV && p) || c == C_USER || c == C_URO)
            e_rd = mdl[key];
      end else begin
         if ((c == C_PRIV && p) || (c == C_URO && p) || c == C_USER) mdl[key] = d;
         if ((c == C_OPP && p) || c == C_OPU) begin
            e_ov = 1; e_oc = code_of(key);
         end
      end
   endtask

   task automatic read_all(bit p, string tag);
      foreach (stored_keys[i]) begin
         int key = stored_keys[i];
         req(0, p, (key >> 10) & 15, (key >> 7) & 7, (key >> 3) & 15, key & 7, 32'h0, tag);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: got hung run exp completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 0; req_valid = 0; req_write = 0; req_priv = 0;
      req_crn = 0; req_opc1 = 0; req_crm = 0; req_opc2 = 0; req_wdata = 0;
      model_reset();
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1;
      idle("R2");               // reset state outputs

      // R1: reset values
      req(0, 1, 0,0,0,0, 0, "R1");
      req(0, 1, 0,0,0,3, 0, "R1");
      read_all(1, "R1");

      // R8: identification registers ignore writes
      req(1, 1, 0,0,0,0, 32'hDEAD_BEEF, "R8");
      req(0, 1, 0,0,0,0, 0, "R8");
      req(1, 1, 0,0,0,3, 32'h1234_5678, "R8");
      req(0, 1, 0,0,0,3, 0, "R8");

      // R12: privileged readback of every stored tuple
      foreach (stored_keys[i]) begin
         int key = stored_keys[i];
         req(1, 1, (key >> 10) & 15, (key >> 7) & 7, (key >> 3) & 15, key & 7,
             32'hA500_0000 ^ (32'(i) * 32'h0101_0101), "R12");
      end
      read_all(1, "R12");

      // R7: user mode cannot read or write privileged registers
      read_all(0, "R7");
      req(1, 0, 1,0,0,0, 32'h0, "R7");
      req(1, 0, 10,0,2,1, 32'h0, "R7");
      req(0, 1, 1,0,0,0, 0, "R7");
      req(0, 1, 10,0,2,1, 0, "R7");

      // R3: user read/write thread register
      req(1, 0, 13,0,0,2, 32'hCAFE_0002, "R3");
      req(0, 0, 13,0,0,2, 0, "R3");
      req(1, 1, 13,0,0,2, 32'h0BAD_0002, "R3");
      req(0, 0, 13,0,0,2, 0, "R3");

      // R4: user read-only thread register
      req(1, 1, 13,0,0,3, 32'h5151_0003, "R4");
      req(0, 0, 13,0,0,3, 0, "R4");
      req(1, 0, 13,0,0,3, 32'hFFFF_FFFF, "R4");
      req(0, 0, 13,0,0,3, 0, "R4");
      req(0, 1, 13,0,0,3, 0, "R4");

      // R5: privileged-only thread register
      req(1, 1, 13,0,0,4, 32'h7777_0004, "R5");
      req(0, 0, 13,0,0,4, 0, "R5");
      req(1, 0, 13,0,0,4, 32'h1111_1111, "R5");
      req(0, 1, 13,0,0,4, 0, "R5");

      // R6: unimplemented tuples
      req(0, 1, 4,0,0,0, 0, "R6");
      req(0, 1, 13,1,0,2, 0, "R6");
      req(1, 1, 11,0,0,0, 32'hFFFF_FFFF, "R6");
      req(1, 1, 1,0,0,3, 32'hFFFF_FFFF, "R6");
      read_all(1, "R6");

      // R9: privileged maintenance pulses, back to back
      req(1, 1, 7,0,5,0, 0, "R9");
      req(1, 1, 7,0,6,0, 0, "R9");
      req(1, 1, 7,0,10,0, 0, "R9");
      req(1, 1, 7,0,14,0, 0, "R9");
      req(1, 1, 8,0,7,0, 0, "R9");
      req(1, 1, 7,0,0,4, 0, "R9");
      req(1, 0, 7,0,6,0, 0, "R9");
      req(1, 0, 8,0,7,0, 0, "R9");
      idle("R9");

      // R10: user-allowed operations
      req(1, 0, 7,0,5,4, 0, "R10");
      req(1, 0, 7,0,10,4, 0, "R10");
      req(1, 0, 7,0,10,5, 0, "R10");
      req(1, 1, 7,0,10,5, 0, "R10");
      idle("R10");

      // R11: reads of operation tuples
      req(0, 1, 7,0,10,4, 0, "R11");
      req(0, 0, 7,0,5,4, 0, "R11");
      req(0, 1, 7,0,14,0, 0, "R11");
      idle("R11");

      // R2: read strobe spacing with gaps
      req(0, 1, 9,0,0,0, 0, "R2");
      idle("R2");
      idle("R2");

      // reset restores values
      @(negedge clk); check_pending(); req_valid = 0; rst_n = 0;
      e_rv = 0; e_rd = 0; e_ov = 0; e_oc = 0; e_tag = "R1";
      @(negedge clk); rst_n = 1; model_reset();
      read_all(1, "R1");
      idle("R1");

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule